// File: doc/BRIEF.md
# Parallel Panel Write-Cycle Generator

This block pushes one frame of pixel words into a display panel's internal frame memory over an 8080-style parallel write bus. Each word becomes one bus cycle. Chip select goes low first. The write strobe pulses low inside that window, and chip select rises again after a hold time. The delays before the strobe, the strobe width and the hold after the strobe come from 4-bit fields of one packed configuration word.

A frame starts on a software trigger strobe. The trigger only counts while the CPU-interface trigger mode is selected and no frame is in progress. The frame size is a programmed width times a programmed height. Pixel words enter on a valid/ready stream together with a register-select bit. The block raises ready only when its bus engine is idle and words of the frame remain. A word transfers on a clock where valid and ready are both high. The source may hold valid high for as long as it likes, and it must keep data and select stable until the transfer. When the last word's cycle finishes, the block pulses frame-done for one clock and becomes triggerable again.

Top module: `lcd_wrcyc_gen`

## Requirements
- R1: Fields of `cfg_word`: bit 0 is the interface enable, [19:16] is the chip-select setup, [15:12] is the strobe setup, [11:8] is the strobe active width and [7:4] is the strobe hold. All counts are in clocks. Other bits are ignored.
- R2: For one word, `cs_n` stays low for csset+wrset+A+hold clocks, where A is the active field with a value of 0 treated as 1. `wr_n` goes low csset+wrset clocks after `cs_n` falls and stays low for exactly A clocks.
- R3: `db` and `rs` equal the accepted word and select bit and stay stable for as long as `cs_n` is low.
- R4: `pix_ready` is high only while a frame is busy, no bus cycle is running and words of the frame remain. After a transfer, `cs_n` falls on the next clock.
- R5: A trigger is taken only when the enable is 1, `trig_sel` is 1 and `busy` is 0. `busy` rises on the following clock.
- R6: A trigger during a busy frame is ignored. The frame still ends after its own word count with a single frame-done, and no new frame starts.
- R7: A frame carries exactly `frame_w*frame_h` words. `frame_done` is high for one clock, one clock after `cs_n` rises at the end of the last word, and `busy` is low in that same clock.
- R8: While the enable is 0, `cs_n` and `wr_n` are high, `busy` is 0 and triggers are ignored. Clearing the enable during a frame ends it without `frame_done`.
- R9: Phase lengths are captured when a trigger is taken. Changing `cfg_word` timing fields mid-frame has no effect until the next frame.
- R10: A trigger with a zero-word frame sets `busy` for one clock, then pulses `frame_done` with no bus cycle.
- R11: After reset, `cs_n` and `wr_n` are 1, and `busy`, `frame_done`, `pix_ready` and `db` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_word | input | 32 | Enable and phase-length fields |
| trig_sel | input | 1 | Trigger mode selects the CPU interface |
| trig_cmd | input | 1 | Software trigger strobe |
| frame_w | input | CNT_W | Words per line |
| frame_h | input | CNT_W | Lines per frame |
| pix_valid | input | 1 | Pixel word offered |
| pix_data | input | DATA_W | Pixel word |
| pix_rs | input | 1 | Register-select level for this word |
| pix_ready | output | 1 | Block accepts a word this clock |
| cs_n | output | 1 | Chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rs | output | 1 | Register select to the panel |
| db | output | DATA_W | Parallel data bus |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-clock end-of-frame pulse |

## Verification
The bench aims at zero-length phases, where a design that skips the zero check would stretch chip select by a stray clock. It also covers an active field of 0, where a missing 0-to-1 rule would give no strobe at all. A second trigger is fired in the middle of a frame: a design that reloads its word counter would never raise frame-done, and the bench's timeout reports it. The timing fields are changed mid-frame to catch a design that reads them live. The enable is dropped mid-frame to catch one that keeps driving the bus or still reports completion. A zero-word frame catches a counter that wraps and asks for a huge frame.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CSS,
    PH_WRS,
    PH_ACT,
    PH_HLD
  } ph_e;

  typedef struct packed {
    logic [3:0] css;
    logic [3:0] wrs;
    logic [3:0] act;
    logic [3:0] hld;
  } tim_t;

  localparam tim_t TIM_RST = '{css: 4'd0, wrs: 4'd0, act: 4'd1, hld: 4'd0};

  function automatic tim_t cfg_to_tim(logic [31:0] w);
    tim_t t;
    t.css = w[19:16];
    t.wrs = w[15:12];
    t.act = w[11:8];
    t.hld = w[7:4];
    return t;
  endfunction

  function automatic ph_e ph_after(ph_e p, tim_t t);
    case (p)
      PH_IDLE: return (t.css != 4'd0) ? PH_CSS : ((t.wrs != 4'd0) ? PH_WRS : PH_ACT);
      PH_CSS:  return (t.wrs != 4'd0) ? PH_WRS : PH_ACT;
      PH_WRS:  return PH_ACT;
      PH_ACT:  return (t.hld != 4'd0) ? PH_HLD : PH_IDLE;
      default: return PH_IDLE;
    endcase
  endfunction

  function automatic logic [3:0] ph_len(ph_e p, tim_t t);
    case (p)
      PH_CSS:  return t.css;
      PH_WRS:  return t.wrs;
      PH_ACT:  return (t.act == 4'd0) ? 4'd1 : t.act;
      PH_HLD:  return t.hld;
      default: return 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/lcdw_cfg_lat.sv
module lcdw_cfg_lat
  import lcdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] cfg_word,
  input  logic        load,
  output logic        en,
  output tim_t        tim
);

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word[31:20], cfg_word[3:1]};

  assign en = cfg_word[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim <= TIM_RST;
    end else if (load) begin
      tim <= cfg_to_tim(cfg_word);
    end
  end

endmodule

// File: rtl/lcdw_frame_ctl.sv
module lcdw_frame_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trig_sel,
  input  logic             trig_cmd,
  input  logic [CNT_W-1:0] frame_w,
  input  logic [CNT_W-1:0] frame_h,
  input  logic             eng_idle,
  input  logic             word_acc,
  output logic             start,
  output logic             busy,
  output logic             frame_done,
  output logic             words_left
);

  localparam int WORDS_W = 2 * CNT_W;

  logic [WORDS_W-1:0] total;
  logic [WORDS_W-1:0] remain;

  assign total      = WORDS_W'(frame_w) * WORDS_W'(frame_h);
  assign start      = en && trig_sel && trig_cmd && !busy;
  assign words_left = (remain != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      frame_done <= 1'b0;
      remain     <= '0;
    end else if (!en) begin
      busy       <= 1'b0;
      frame_done <= 1'b0;
      remain     <= '0;
    end else begin
      frame_done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        remain <= total;
      end else if (busy) begin
        if (word_acc) begin
          remain <= remain - WORDS_W'(1);
        end else if (eng_idle && !words_left) begin
          busy       <= 1'b0;
          frame_done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lcdw_cycle_eng.sv
module lcdw_cycle_eng
  import lcdw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  tim_t              tim,
  input  logic              acc,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rs_in,
  output logic              cs_n,
  output logic              wr_n,
  output logic              rs,
  output logic [DATA_W-1:0] db,
  output logic              idle
);

  ph_e        phase;
  ph_e        nxt;
  logic [3:0] nxt_len;
  logic [3:0] cnt;

  always_comb begin
    nxt     = ph_after(phase, tim);
    nxt_len = ph_len(nxt, tim);
  end

  assign idle = (phase == PH_IDLE);
  assign cs_n = (phase == PH_IDLE);
  assign wr_n = (phase != PH_ACT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= 4'd0;
      db    <= '0;
      rs    <= 1'b0;
    end else if (!en) begin
      phase <= PH_IDLE;
      cnt   <= 4'd0;
    end else if (phase == PH_IDLE) begin
      if (acc) begin
        db    <= data_in;
        rs    <= rs_in;
        phase <= nxt;
        cnt   <= nxt_len - 4'd1;
      end
    end else if (cnt == 4'd0) begin
      phase <= nxt;
      cnt   <= nxt_len - 4'd1;
    end else begin
      cnt <= cnt - 4'd1;
    end
  end

endmodule

// File: rtl/lcd_wrcyc_gen.sv
module lcd_wrcyc_gen
  import lcdw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic              trig_sel,
  input  logic              trig_cmd,
  input  logic [CNT_W-1:0]  frame_w,
  input  logic [CNT_W-1:0]  frame_h,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_rs,
  output logic              pix_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic              rs,
  output logic [DATA_W-1:0] db,
  output logic              busy,
  output logic              frame_done
);

  logic en;
  logic start;
  logic eng_idle;
  logic words_left;
  logic word_acc;
  tim_t tim;

  assign pix_ready = busy && eng_idle && words_left;
  assign word_acc  = pix_valid && pix_ready;

  lcdw_cfg_lat u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .load     (start),
    .en       (en),
    .tim      (tim)
  );

  lcdw_frame_ctl #(.CNT_W(CNT_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .trig_sel   (trig_sel),
    .trig_cmd   (trig_cmd),
    .frame_w    (frame_w),
    .frame_h    (frame_h),
    .eng_idle   (eng_idle),
    .word_acc   (word_acc),
    .start      (start),
    .busy       (busy),
    .frame_done (frame_done),
    .words_left (words_left)
  );

  lcdw_cycle_eng #(.DATA_W(DATA_W)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .tim     (tim),
    .acc     (word_acc),
    .data_in (pix_data),
    .rs_in   (pix_rs),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .rs      (rs),
    .db      (db),
    .idle    (eng_idle)
  );

endmodule

// File: rtl/lcdw_checker.sv
module lcdw_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              cs_n,
  input logic              wr_n,
  input logic              rs,
  input logic [DATA_W-1:0] db,
  input logic              busy,
  input logic              frame_done
);

  AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n); // R2

  AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n)) |-> ($stable(db) && $stable(rs))); // R3

  AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (cs_n && busy)); // R4

  AST_SELECT_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready && en) |=> !cs_n); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R7

  AST_END_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> frame_done); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cs_n && wr_n && !busy)); // R8

endmodule

bind lcd_wrcyc_gen lcdw_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (cfg_word[0]),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .cs_n       (cs_n),
  .wr_n       (wr_n),
  .rs         (rs),
  .db         (db),
  .busy       (busy),
  .frame_done (frame_done)
);

// File: tb/tb_lcd_wrcyc_gen.sv
`timescale 1ns/1ps
module tb_lcd_wrcyc_gen;

  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   cfg_word = 32'h0;
  logic          trig_sel = 1'b0;
  logic          trig_cmd = 1'b0;
  logic [CW-1:0] frame_w = '0;
  logic [CW-1:0] frame_h = '0;
  logic          pix_valid = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic          pix_rs = 1'b0;
  logic          pix_ready, cs_n, wr_n, rs, busy, frame_done;
  logic [DW-1:0] db;

  always #2 clk = ~clk;

  lcd_wrcyc_gen #(.DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .trig_sel(trig_sel),
    .trig_cmd(trig_cmd), .frame_w(frame_w), .frame_h(frame_h),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_rs(pix_rs),
    .pix_ready(pix_ready), .cs_n(cs_n), .wr_n(wr_n), .rs(rs), .db(db),
    .busy(busy), .frame_done(frame_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // expectations set by the main flow
  int exp_css = 0, exp_wrs = 0, exp_act = 1, exp_hld = 0;
  int exp_words = 0;
  int frame_base = 0;
  logic [DW:0] expq[$];

  // monitor state
  int wcnt = 0, done_cnt = 0, cyc = 0, last_rise = -10;
  int cs_cnt = 0, wr_cnt = 0, wr_off = -1;
  logic prev_cs = 1'b1, prev_acc = 1'b0;
  logic [DW:0] cur = '0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(int css, int wrs, int act, int hld, bit en);
    return {12'h0, 4'(css), 4'(wrs), 4'(act), 4'(hld), 3'b0, en};
  endfunction

  function automatic int act_eff(int a);
    return (a == 0) ? 1 : a;
  endfunction

  // passive monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_acc) check(!cs_n && prev_cs, "R4", "cs_n fall after transfer", int'(cs_n), 0);
      if (!cs_n) begin
        if (prev_cs) begin
          cs_cnt = 0; wr_cnt = 0; wr_off = -1;
          cur = {rs, db};
          if (expq.size() == 0) check(1'b0, "R3", "unexpected word", int'(cur), -1);
          else begin
            logic [DW:0] e;
            e = expq.pop_front();
            check(cur == e, "R3", "word on bus", int'(cur), int'(e));
          end
        end else if ({rs, db} != cur) begin
          check(1'b0, "R3", "bus changed under cs_n", int'({rs, db}), int'(cur));
        end
        if (!wr_n) begin
          if (wr_cnt == 0) wr_off = cs_cnt;
          wr_cnt++;
        end
        cs_cnt++;
      end else if (!prev_cs) begin
        check(cs_cnt == exp_css + exp_wrs + act_eff(exp_act) + exp_hld, "R1 R2",
              "cs_n low clocks", cs_cnt, exp_css + exp_wrs + act_eff(exp_act) + exp_hld);
        check(wr_off == exp_css + exp_wrs, "R1 R2", "wr_n offset", wr_off, exp_css + exp_wrs);
        check(wr_cnt == act_eff(exp_act), "R2", "wr_n low clocks", wr_cnt, act_eff(exp_act));
        wcnt++;
        last_rise = cyc;
      end
      if (!wr_n && cs_n) check(1'b0, "R2", "strobe outside select", 0, 1);
      if (frame_done) begin
        done_cnt++;
        check(wcnt - frame_base == exp_words, "R7", "words in frame", wcnt - frame_base, exp_words);
        if (exp_words > 0) check(cyc == last_rise + 1, "R7", "done cycle", cyc, last_rise + 1);
        check(!busy, "R7", "busy with done", int'(busy), 0);
      end
      prev_acc = pix_valid && pix_ready && cfg_word[0];
      prev_cs = cs_n;
    end
  end

  task automatic send_words(int n);
    for (int i = 0; i < n; i++) begin
      int gap;
      gap = $urandom_range(0, 2);
      repeat (gap) @(negedge clk);
      pix_valid = 1'b1;
      pix_data = DW'($urandom);
      pix_rs = 1'($urandom);
      expq.push_back({pix_rs, pix_data});
      while (!pix_ready) @(negedge clk);
      @(negedge clk);
      pix_valid = 1'b0;
    end
  endtask

  task automatic pulse_trig();
    trig_cmd = 1'b1;
    @(negedge clk);
    trig_cmd = 1'b0;
  endtask

  task automatic run_frame(int w, int h, int css, int wrs, int act, int hld,
                           bit extra_trig, bit mid_cfg);
    int d0;
    int t;
    cfg_word = mk_cfg(css, wrs, act, hld, 1'b1);
    frame_w = CW'(w);
    frame_h = CW'(h);
    exp_css = css; exp_wrs = wrs; exp_act = act; exp_hld = hld;
    exp_words = w * h;
    frame_base = wcnt;
    d0 = done_cnt;
    trig_sel = 1'b1;
    pulse_trig();
    check(busy, "R5", "busy after trigger", int'(busy), 1);
    fork
      send_words(w * h);
      begin
        if (extra_trig) begin
          repeat (3) @(negedge clk);
          pulse_trig();  // R6: ignored
        end
      end
      begin
        if (mid_cfg) begin
          repeat (2) @(negedge clk);
          cfg_word = mk_cfg(css ^ 1, wrs ^ 2, act ^ 3, hld ^ 1, 1'b1);  // R9
        end
      end
    join
    t = 0;
    while (done_cnt == d0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    check(done_cnt == d0 + 1, "R6 R7", "done pulses", done_cnt - d0, 1);
    @(negedge clk);
    check(!busy && !frame_done, "R6", "idle after frame", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cs_n && wr_n, "R11", "strobes in reset", int'({cs_n, wr_n}), 3);
    check(!busy && !frame_done && !pix_ready, "R11", "flags in reset",
          int'({busy, frame_done, pix_ready}), 0);
    check(db == '0, "R11", "bus in reset", int'(db), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed: default lengths, zero active, long phases
    run_frame(1, 1, 0, 0, 1, 0, 1'b0, 1'b0);
    run_frame(2, 2, 0, 0, 0, 0, 1'b0, 1'b0);   // R2 active 0 acts as 1
    run_frame(3, 2, 3, 2, 4, 2, 1'b1, 1'b0);   // R6
    run_frame(2, 3, 1, 0, 2, 3, 1'b0, 1'b1);   // R9
    run_frame(2, 2, 15, 15, 15, 15, 1'b1, 1'b1);

    // R10 zero-word frame
    cfg_word = mk_cfg(1, 1, 1, 1, 1'b1);
    frame_w = '0; frame_h = CW'(5);
    exp_words = 0; frame_base = wcnt;
    pulse_trig();
    check(busy, "R10", "busy on empty frame", int'(busy), 1);
    @(negedge clk);
    check(frame_done && !busy && cs_n, "R10", "done on empty frame", int'(frame_done), 1);
    @(negedge clk);

    // R5 trigger with trig_sel low
    trig_sel = 1'b0;
    frame_w = CW'(2); frame_h = CW'(2);
    pulse_trig();
    check(!busy, "R5", "trigger without CPU mode", int'(busy), 0);
    trig_sel = 1'b1;

    // R8 abort by enable drop
    begin
      int d0;
      cfg_word = mk_cfg(1, 0, 2, 1, 1'b1);
      exp_css = 1; exp_wrs = 0; exp_act = 2; exp_hld = 1;
      frame_w = CW'(3); frame_h = CW'(2);
      d0 = done_cnt;
      pulse_trig();
      send_words(2);
      while (!pix_ready) @(negedge clk);
      cfg_word[0] = 1'b0;
      @(negedge clk);
      check(cs_n && wr_n && !busy && !pix_ready, "R8", "quiet after enable drop",
            int'({cs_n, wr_n, busy}), 6);
      repeat (10) @(negedge clk);
      check(done_cnt == d0, "R8", "no done on abort", done_cnt - d0, 0);
      pulse_trig();
      @(negedge clk);
      check(!busy && cs_n && wr_n, "R8", "trigger while disabled", int'(busy), 0);
    end

    // constrained random frames
    for (int k = 0; k < 10; k++) begin
      run_frame($urandom_range(1, 4), $urandom_range(1, 3), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 4), $urandom_range(0, 3),
                1'($urandom), 1'($urandom));
    end

    check(expq.size() == 0, "R3", "words left unsent", expq.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule